// File: doc/BRIEF.md
# Interval, Fixed-Period and Watchdog Timer Unit

This block provides three timers for an embedded processor core. All three are driven by one time-base tick that arrives from outside. A programmable interval timer counts down from a reload value that software writes. It can reload itself automatically. A fixed-period timer flags every 2^e ticks, where the exponent comes from a selector field. A two-stage watchdog escalates on each of its periods that software leaves unserviced. It first raises a warning status bit, then an interrupt, and finally requests the reset that software has chosen.

Software sees a 32-bit control register, a 32-bit status register and the reload value. All three are written through one write port that has a 2-bit register select. The status register is write-one-to-clear. The block drives three level interrupt lines and three one-cycle reset request pulses: core, chip and system. The reset controller and the time base lie outside the block.

Top module: `tmr_unit`

## Requirements
- R1: Write select encoding is 0 = control, 1 = status, 2 = reload, 3 = unused. A control write stores data bits 31:22, and bits 21:0 read as 0. A write with select 3 changes no register.
- R2: A status write clears each of bits 31:26 that is written as 1. Bits written as 0 are unchanged. Status bits 25:0 always read 0.
- R3: A tick counter runs freely from reset and is never restarted by a write. Let e = FIT_BASE + SEL_STEP * ctrl[25:24]. Status bit 26 is set on every tick at which the low e bits of the counter are all ones, which is once every 2^e ticks.
- R4: Each interrupt output is high exactly while its status bit and its enable bit are both 1. The pairs are: interval irq = stat[27] & ctrl[26], fixed irq = stat[26] & ctrl[23], watchdog irq = stat[30] & ctrl[27].
- R5: A watchdog period ends on every tick at which the low WDT_BASE + SEL_STEP * ctrl[31:30] bits of the tick counter are all ones.
- R6: At the end of a watchdog period, status bit 31 is set if it is clear. Otherwise status bit 30 is set if it is clear. Bit 30 never rises unless bit 31 was set before.
- R7: When a watchdog period ends with status bits 31 and 30 both set, ctrl[29:28] is copied into stat[29:28]. The reset selected by that value is then requested: 1 = core, 2 = chip, 3 = system, 0 = none. The copied value stays until software clears it.
- R8: Each reset request is a pulse one clock wide, and at most one request is high at a time.
- R9: A reload write loads both the reload value and the count. Counting restarts from the new value, and the current count is visible on pit_count.
- R10: The count drops by one per tick only while ctrl[26] is 1 and the timer is running. It holds otherwise. The tick on which the count is 1 is the expiry, and it sets stat[27].
- R11: When ctrl[22] is 1, an expiry reloads the count, so expiries fall exactly N ticks apart for reload value N. When ctrl[22] is 0, an expiry stops the timer with the count at 0.
- R12: A reload value of 0 or 1 leaves the timer stopped, and the timer never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base tick, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| ctrl_out | output | 32 | Control register contents |
| stat_out | output | 32 | Status register contents |
| pit_count | output | RLD_W | Interval timer current count |
| irq_pit | output | 1 | Interval timer interrupt |
| irq_fit | output | 1 | Fixed-period timer interrupt |
| irq_wdt | output | 1 | Watchdog interrupt |
| req_core_rst | output | 1 | Core reset request pulse |
| req_chip_rst | output | 1 | Chip reset request pulse |
| req_sys_rst | output | 1 | System reset request pulse |

## Verification
The assertions check several properties on every cycle:
- Watchdog stage 2 is reached only through stage 1, and a reset request follows only an expiry in the final stage.
- A system request always comes with the copied type 3 in status.
- Reset requests are one-hot.
- The interval count holds while counting is disabled.
- An interval expiry never occurs with a reload value below 2.

Only the bench scenarios can show the exact periods of both selectors over all four settings, the drift-free spacing of auto-reloaded expiries, the restart on a rewrite, the write-one-to-clear behaviour and the one-cycle width of each reset type. The bench shows these by comparing every output after every tick against an arithmetic model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STAT   = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam logic [31:0] CTRL_MASK = 32'hFFC0_0000;
    localparam logic [31:0] STAT_MASK = 32'hFC00_0000;

    // control bit positions
    localparam int C_WD_PER   = 30;  // [31:30]
    localparam int C_WD_RST   = 28;  // [29:28]
    localparam int C_WD_IE    = 27;
    localparam int C_PIT_EN   = 26;
    localparam int C_FIT_PER  = 24;  // [25:24]
    localparam int C_FIT_IE   = 23;
    localparam int C_PIT_AR   = 22;

    // status bit positions
    localparam int S_WD_WARN  = 31;
    localparam int S_WD_IRQ   = 30;
    localparam int S_WD_RST   = 28;  // [29:28]
    localparam int S_PIT      = 27;
    localparam int S_FIT      = 26;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] stat;
        logic [2:0]  rst_req;  // {sys, chip, core}
    } unit_state_t;

endpackage

// File: rtl/tmr_timebase_cnt.sv
module tmr_timebase_cnt #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_tap_select.sv
module tmr_tap_select #(
    parameter int CNT_W = 29,
    parameter int BASE  = 9,
    parameter int STEP  = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic [1:0]       sel,
    output logic             hit
);
    function automatic logic [CNT_W-1:0] low_ones(input int n);
        logic [CNT_W-1:0] r;
        for (int b = 0; b < CNT_W; b++) r[b] = (b < n);
        return r;
    endfunction

    logic [3:0] hit_vec;

    for (genvar i = 0; i < 4; i++) begin : g_tap
        localparam logic [CNT_W-1:0] TAP_MASK = low_ones(BASE + STEP * i);
        assign hit_vec[i] = tick && ((cnt & TAP_MASK) == TAP_MASK);
    end

    assign hit = hit_vec[sel];
endmodule

// File: rtl/tmr_pit.sv
module tmr_pit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         auto_rld,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] count;
        logic         run;
    } pit_state_t;

    pit_state_t d, q;

    always_comb begin
        d      = q;
        expire = 1'b0;
        if (ld) begin
            d.reload = ld_val;
            d.count  = ld_val;
            d.run    = (ld_val > W'(1));
        end else if (tick && en && q.run) begin
            if (q.count == W'(1)) begin
                expire = 1'b1;
                if (auto_rld) begin
                    d.count = q.reload;
                end else begin
                    d.count = '0;
                    d.run   = 1'b0;
                end
            end else begin
                d.count = q.count - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.count;

    logic [W-1:0] reload_q;
    assign reload_q = q.reload;

    // R12
    pit_min_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (reload_q > W'(1)));

    // R10
    pit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !en) |=> $stable(count));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int FIT_BASE = 9,
    parameter int WDT_BASE = 17,
    parameter int SEL_STEP = 4,
    parameter int RLD_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    output logic [31:0]      ctrl_out,
    output logic [31:0]      stat_out,
    output logic [RLD_W-1:0] pit_count,
    output logic             irq_pit,
    output logic             irq_fit,
    output logic             irq_wdt,
    output logic             req_core_rst,
    output logic             req_chip_rst,
    output logic             req_sys_rst
);
    localparam int TOP_BASE = (FIT_BASE > WDT_BASE) ? FIT_BASE : WDT_BASE;
    localparam int TB_W     = TOP_BASE + 3 * SEL_STEP;

    unit_state_t d, q;

    logic [TB_W-1:0] tb_cnt;
    logic            fit_hit, wd_hit, pit_exp;
    logic            wr_ctrl, wr_stat, wr_rld;

    assign wr_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    assign wr_stat = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);
    assign wr_rld  = wr_en && (reg_sel_e'(wr_sel) == SEL_RELOAD);

    tmr_timebase_cnt #(.CNT_W(TB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(tb_cnt)
    );

    tmr_tap_select #(.CNT_W(TB_W), .BASE(FIT_BASE), .STEP(SEL_STEP)) u_fit_tap (
        .cnt(tb_cnt), .tick(tick),
        .sel(q.ctrl[C_FIT_PER +: 2]), .hit(fit_hit)
    );

    tmr_tap_select #(.CNT_W(TB_W), .BASE(WDT_BASE), .STEP(SEL_STEP)) u_wd_tap (
        .cnt(tb_cnt), .tick(tick),
        .sel(q.ctrl[C_WD_PER +: 2]), .hit(wd_hit)
    );

    tmr_pit #(.W(RLD_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .en(q.ctrl[C_PIT_EN]), .auto_rld(q.ctrl[C_PIT_AR]),
        .ld(wr_rld), .ld_val(wr_data[RLD_W-1:0]),
        .count(pit_count), .expire(pit_exp)
    );

    logic [31:0] stat_w;

    always_comb begin
        d         = q;
        d.rst_req = '0;
        if (wr_ctrl) d.ctrl = wr_data & CTRL_MASK;

        stat_w = q.stat & ~(wr_stat ? (wr_data & STAT_MASK) : 32'h0);
        if (fit_hit) stat_w[S_FIT] = 1'b1;
        if (pit_exp) stat_w[S_PIT] = 1'b1;
        if (wd_hit) begin
            if (!stat_w[S_WD_WARN]) begin
                stat_w[S_WD_WARN] = 1'b1;
            end else if (!stat_w[S_WD_IRQ]) begin
                stat_w[S_WD_IRQ] = 1'b1;
            end else begin
                stat_w[S_WD_RST +: 2] = q.ctrl[C_WD_RST +: 2];
                case (q.ctrl[C_WD_RST +: 2])
                    2'd1:    d.rst_req = 3'b001;
                    2'd2:    d.rst_req = 3'b010;
                    2'd3:    d.rst_req = 3'b100;
                    default: d.rst_req = 3'b000;
                endcase
            end
        end
        d.stat = stat_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_out     = q.ctrl;
    assign stat_out     = q.stat;
    assign irq_pit      = q.stat[S_PIT]    & q.ctrl[C_PIT_EN];
    assign irq_fit      = q.stat[S_FIT]    & q.ctrl[C_FIT_IE];
    assign irq_wdt      = q.stat[S_WD_IRQ] & q.ctrl[C_WD_IE];
    assign req_core_rst = q.rst_req[0];
    assign req_chip_rst = q.rst_req[1];
    assign req_sys_rst  = q.rst_req[2];

    // R6
    wd_stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_out[S_WD_IRQ]) |-> $past(stat_out[S_WD_WARN]));

    // R7
    rst_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_core_rst || req_chip_rst || req_sys_rst)
            |-> $past(stat_out[S_WD_WARN] && stat_out[S_WD_IRQ]));

    // R7
    sys_type_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_sys_rst |-> (stat_out[S_WD_RST +: 2] == 2'd3));

    // R8
    rst_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_core_rst, req_chip_rst, req_sys_rst}));
endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [31:0]   wr_data = 32'h0;
    logic [31:0]   ctrl_out, stat_out;
    logic [RW-1:0] pit_count;
    logic          irq_pit, irq_fit, irq_wdt;
    logic          req_core_rst, req_chip_rst, req_sys_rst;

    tmr_unit #(.FIT_BASE(2), .WDT_BASE(3), .SEL_STEP(1), .RLD_W(RW)) u_tmr_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_out(ctrl_out), .stat_out(stat_out), .pit_count(pit_count),
        .irq_pit(irq_pit), .irq_fit(irq_fit), .irq_wdt(irq_wdt),
        .req_core_rst(req_core_rst), .req_chip_rst(req_chip_rst),
        .req_sys_rst(req_sys_rst)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model
    logic [31:0] m_ctrl = 32'h0;
    logic [31:0] m_stat = 32'h0;
    int          m_reload = 0;
    int          m_count = 0;
    bit          m_run = 1'b0;
    int          nticks = 0;
    logic [2:0]  exp_rst = 3'b000;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(ctrl_out === m_ctrl, "R1", "ctrl", ctrl_out, m_ctrl);
        check(stat_out === m_stat, req, "stat", stat_out, m_stat);
        check(pit_count === RW'(m_count), "R9", "pit_count",
              32'(pit_count), 32'(RW'(m_count)));
        check(irq_pit === (m_stat[27] & m_ctrl[26]), "R4", "irq_pit",
              32'(irq_pit), 32'(m_stat[27] & m_ctrl[26]));
        check(irq_fit === (m_stat[26] & m_ctrl[23]), "R4", "irq_fit",
              32'(irq_fit), 32'(m_stat[26] & m_ctrl[23]));
        check(irq_wdt === (m_stat[30] & m_ctrl[27]), "R4", "irq_wdt",
              32'(irq_wdt), 32'(m_stat[30] & m_ctrl[27]));
        check({req_sys_rst, req_chip_rst, req_core_rst} === exp_rst, req, "rst_req",
              32'({req_sys_rst, req_chip_rst, req_core_rst}), 32'(exp_rst));
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        case (sel)
            2'd0: m_ctrl = data & 32'hFFC0_0000;
            2'd1: m_stat = m_stat & ~(data & 32'hFC00_0000);
            2'd2: begin
                m_reload = int'(data[RW-1:0]);
                m_count  = m_reload;
                m_run    = (m_reload > 1);
            end
            default: ;
        endcase
        exp_rst = 3'b000;
        @(negedge clk);
        wr_en = 1'b0;
        compare_all(req);
    endtask

    task automatic model_tick();
        int fit_p, wd_p, rt;
        fit_p = 1 << (2 + int'(m_ctrl[25:24]));
        wd_p  = 1 << (3 + int'(m_ctrl[31:30]));
        exp_rst = 3'b000;
        if ((nticks % fit_p) == fit_p - 1) m_stat[26] = 1'b1;
        if (m_run && m_ctrl[26]) begin
            if (m_count == 1) begin
                m_stat[27] = 1'b1;
                if (m_ctrl[22]) m_count = m_reload;
                else begin m_run = 1'b0; m_count = 0; end
            end else begin
                m_count--;
            end
        end
        if ((nticks % wd_p) == wd_p - 1) begin
            if (!m_stat[31]) m_stat[31] = 1'b1;
            else if (!m_stat[30]) m_stat[30] = 1'b1;
            else begin
                m_stat[29:28] = m_ctrl[29:28];
                rt = int'(m_ctrl[29:28]);
                if (rt != 0) exp_rst[rt-1] = 1'b1;
            end
        end
        nticks++;
    endtask

    task automatic step(input string req);
        @(negedge clk);
        tick = 1'b1;
        model_tick();
        @(negedge clk);
        tick = 1'b0;
        compare_all(req);
        if (exp_rst != 3'b000) begin
            @(negedge clk);
            exp_rst = 3'b000;
            compare_all("R8");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R2");            // reset state: all zero
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R1: only bits 31:22 stored, select 3 ignored
        write_reg(2'd0, 32'hFFFF_FFFF, "R1");
        write_reg(2'd3, 32'h0000_0000, "R1");
        write_reg(2'd0, 32'h0000_0000, "R1");
        write_reg(2'd3, 32'hFFFF_FFFF, "R1");

        // R3: fixed-period sweep over selector and enable
        for (int s = 0; s < 4; s++) begin
            for (int ie = 0; ie < 2; ie++) begin
                write_reg(2'd0, (32'(s) << 24) | (32'(ie) << 23), "R3");
                for (int k = 0; k < 40; k++) begin
                    step("R3");
                    if (m_stat[26]) write_reg(2'd1, 32'h0400_0000, "R2");
                end
            end
        end

        // R5, R6, R7: watchdog period, staging and reset type sweep
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                write_reg(2'd0, (32'(s) << 30) | (32'(t) << 28) | (32'(t & 1) << 27), "R5");
                write_reg(2'd1, 32'hFC00_0000, "R2");
                for (int k = 0; k < (4 << (3 + s)); k++) step((t == 0) ? "R6" : "R7");
            end
        end

        // R2: selective write-one-to-clear, zero writes and low bits
        write_reg(2'd1, 32'h4000_0000, "R2");
        write_reg(2'd1, 32'h0000_0000, "R2");
        write_reg(2'd1, 32'h03FF_FFFF, "R2");
        write_reg(2'd1, 32'h3000_0000, "R2");
        write_reg(2'd1, 32'hFC00_0000, "R2");
        write_reg(2'd0, 32'h0000_0000, "R1");

        // R10, R11, R12: interval timer reload values with and without auto-reload
        for (int ar = 0; ar < 2; ar++) begin
            for (int vi = 0; vi < 6; vi++) begin
                int v;
                string tag;
                case (vi)
                    0: v = 0; 1: v = 1; 2: v = 2; 3: v = 3; 4: v = 5; default: v = 9;
                endcase
                tag = (v < 2) ? "R12" : ((ar == 1) ? "R11" : "R10");
                write_reg(2'd0, (32'h1 << 26) | (32'(ar) << 22), tag);
                write_reg(2'd1, 32'hFC00_0000, "R2");
                write_reg(2'd2, 32'(v), "R9");
                for (int k = 0; k < 3 * v + 5; k++) begin
                    step(tag);
                    if (m_stat[27]) write_reg(2'd1, 32'h0800_0000, "R2");
                end
            end
        end

        // R9: rewrite restarts from the new value
        write_reg(2'd0, 32'h1 << 26, "R9");
        write_reg(2'd2, 32'd9, "R9");
        repeat (4) step("R9");
        write_reg(2'd2, 32'd6, "R9");
        repeat (7) step("R9");

        // R10: counting holds while disabled
        write_reg(2'd0, (32'h1 << 26) | (32'h1 << 22), "R10");
        write_reg(2'd2, 32'd5, "R10");
        repeat (2) step("R10");
        write_reg(2'd0, 32'h1 << 22, "R10");
        repeat (4) step("R10");
        write_reg(2'd0, (32'h1 << 26) | (32'h1 << 22), "R10");
        repeat (12) step("R11");

        finish_run();
    end
endmodule